// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block owns the program counter of a single-issue core with one architectural delay slot. Each cycle it receives the decode results for the instruction currently being fetched: whether it is an equal-compare branch, an unequal-compare branch, a direct jump, a register jump, or a linking transfer. It also receives the register-compare outcome, the 16-bit branch offset, the 26-bit jump field and the register value for a register jump. From these it produces the next fetch address and the return address for linking transfers.

A taken transfer does not redirect fetch at once. The unit stores the computed target for one cycle, lets the sequentially following instruction (the delay slot) be fetched, and then loads the target. A control transfer that is decoded while a redirect is pending sits in a delay slot. It is ignored and flagged on an error output.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, sets `fetchAddr` to the reset address (0 by default) and clears any pending redirect, so the fetch after reset is reset address + 4.
- R2: With no control transfer and no pending redirect, `fetchAddr` increases by 4 at every rising edge.
- R3: An equal-compare branch (`isBeq`) is taken when `regsEqual` is 1. When `regsEqual` is 0 it behaves like a plain instruction.
- R4: An unequal-compare branch (`isBne`) is taken when `regsEqual` is 0. When `regsEqual` is 1 it behaves like a plain instruction.
- R5: A branch at address A targets A + 4 + (sign-extended `branchOffset` × 4). This holds over the whole offset range, from 0x8000 (most negative) to 0x7FFF.
- R6: A direct jump at address A targets {(A+4)[31:28], `jumpField`, 2'b00}. The region bits come from A+4, so a jump in the last word of a 256 MiB region uses the next region.
- R7: A register jump targets `jrValue` unchanged.
- R8: After a taken transfer at address A, the next `fetchAddr` is A+4 (the delay slot) and the one after that is the target.
- R9: A transfer decoded while a redirect is pending (`isBeq`, `isBne`, `isJump` or `isJr` asserted) has no effect on the fetch sequence. `slotError` is 1 in that cycle and 0 in every other cycle.
- R10: `linkValue` always equals `fetchAddr` + 8. `linkValid` equals `isLink` outside a delay slot and is 0 inside one.
- R11: When several transfer flags are set together, the register jump wins over the direct jump, and the direct jump wins over the branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| isBeq | input | 1 | Current instruction is an equal-compare branch |
| isBne | input | 1 | Current instruction is an unequal-compare branch |
| isJump | input | 1 | Current instruction is a direct (region) jump |
| isJr | input | 1 | Current instruction is a register jump |
| isLink | input | 1 | Current instruction writes a return address |
| regsEqual | input | 1 | Compare result of the two source registers |
| branchOffset | input | 16 | Word offset of a branch, two's complement |
| jumpField | input | 26 | Word index of a direct jump within its region |
| jrValue | input | 32 | Register value for a register jump |
| fetchAddr | output | 32 | Address of the instruction being fetched |
| linkValue | output | 32 | Return address (fetch address + 8) |
| linkValid | output | 1 | Return address should be written |
| slotError | output | 1 | Transfer found in a delay slot and ignored |

## Verification
The bench sweeps branch offsets, including both extremes, with the compare result set both ways. A unit that used the branch's own address as the base, or that zero-extended the offset, would land one word off or far forward. A direct jump is placed in the last word of a region. Taking the region bits from the jump's own address instead of the following one would keep the old region. Transfers are placed in delay slots, and a reset is applied while a redirect is pending. A unit that honoured the second transfer, cancelled the pending one, or kept the pending target across reset would fetch the wrong address. Combined flags check the target priority.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_BRANCH = 2'd0,
    SRC_JUMP   = 2'd1,
    SRC_REG    = 2'd2
  } tgt_src_e;

  typedef struct packed {
    logic     capture;   // latch a new target this cycle
    logic     redirect;  // load pc from the held target this cycle
    tgt_src_e src;       // which target feeds the capture
  } npc_strobe_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        isBeq,
  input  logic        isBne,
  input  logic        isJump,
  input  logic        isJr,
  input  logic        isLink,
  input  logic        regsEqual,
  output npc_strobe_t strobes,
  output logic        slotError,
  output logic        linkValid
);
  logic pendValid;
  logic anyCtl;
  logic branchTaken;
  logic takeNow;

  assign anyCtl      = isBeq | isBne | isJump | isJr;
  assign branchTaken = (isBeq & regsEqual) | (isBne & ~regsEqual);
  assign takeNow     = ~pendValid & (isJr | isJump | branchTaken);

  always_comb begin
    strobes.capture  = takeNow;
    strobes.redirect = pendValid;
    if (isJr)        strobes.src = SRC_REG;
    else if (isJump) strobes.src = SRC_JUMP;
    else             strobes.src = SRC_BRANCH;
  end

  assign slotError = pendValid & anyCtl;
  assign linkValid = isLink & ~pendValid;

  always_ff @(posedge clk) begin
    if (rst) pendValid <= 1'b0;
    else     pendValid <= takeNow;
  end

  // R8: a pending redirect lasts exactly one cycle
  p_single_slot_r8: assert property (@(posedge clk) disable iff (rst)
    pendValid |=> !pendValid);
  // R9: a flagged delay-slot transfer never creates a redirect
  p_slot_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    slotError |=> !strobes.redirect);
  // R3: a taken equal branch outside a slot leads to a redirect
  p_beq_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (isBeq && regsEqual && !pendValid) |=> strobes.redirect);
  // R4: a taken unequal branch outside a slot leads to a redirect
  p_bne_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (isBne && !regsEqual && !pendValid) |=> strobes.redirect);
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          OFF_W      = 16,
  parameter int          JF_W       = 26,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  npc_strobe_t       strobes,
  input  logic [OFF_W-1:0]  branchOffset,
  input  logic [JF_W-1:0]   jumpField,
  input  logic [ADDR_W-1:0] jrValue,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] linkValue
);
  localparam int EXT_W    = ADDR_W - OFF_W - 2;
  localparam int REGION_W = ADDR_W - JF_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] offBytes;
  logic [ADDR_W-1:0] branchTgt;
  logic [ADDR_W-1:0] jumpTgt;
  logic [ADDR_W-1:0] pendTarget;
  logic [ADDR_W-1:0] newTarget;

  assign pcPlus4   = pc + STEP;
  assign linkValue = pc + (STEP << 1);

  generate
    if (EXT_W > 0) begin : g_ext
      assign offBytes = {{EXT_W{branchOffset[OFF_W-1]}}, branchOffset, 2'b00};
    end else begin : g_noext
      assign offBytes = {branchOffset[ADDR_W-3:0], 2'b00};
    end
    if (REGION_W > 0) begin : g_region
      assign jumpTgt = {pcPlus4[ADDR_W-1 -: REGION_W], jumpField, 2'b00};
    end else begin : g_flat
      assign jumpTgt = {jumpField[ADDR_W-3:0], 2'b00};
    end
  endgenerate

  assign branchTgt = pcPlus4 + offBytes;

  always_comb begin
    unique case (strobes.src)
      SRC_REG:  newTarget = jrValue;
      SRC_JUMP: newTarget = jumpTgt;
      default:  newTarget = branchTgt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= RESET_ADDR[ADDR_W-1:0];
      pendTarget <= '0;
    end else begin
      pc <= strobes.redirect ? pendTarget : pcPlus4;
      if (strobes.capture) pendTarget <= newTarget;
    end
  end

  // R1: reset loads the start address
  p_reset_addr_r1: assert property (@(posedge clk)
    rst |=> pc == RESET_ADDR[ADDR_W-1:0]);
  // R2: without a redirect the pc steps by one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    !strobes.redirect |=> pc == $past(pc) + STEP);
  // R8: a redirect loads the held target
  p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.redirect |=> pc == $past(pendTarget));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          OFF_W      = 16,
  parameter int          JF_W       = 26,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isBeq,
  input  logic              isBne,
  input  logic              isJump,
  input  logic              isJr,
  input  logic              isLink,
  input  logic              regsEqual,
  input  logic [OFF_W-1:0]  branchOffset,
  input  logic [JF_W-1:0]   jumpField,
  input  logic [ADDR_W-1:0] jrValue,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] linkValue,
  output logic              linkValid,
  output logic              slotError
);
  npc_strobe_t strobes;

  npc_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .isBeq(isBeq), .isBne(isBne), .isJump(isJump), .isJr(isJr),
    .isLink(isLink), .regsEqual(regsEqual),
    .strobes(strobes), .slotError(slotError), .linkValid(linkValid)
  );

  npc_datapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .JF_W(JF_W), .RESET_ADDR(RESET_ADDR)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .branchOffset(branchOffset), .jumpField(jumpField), .jrValue(jrValue),
    .pc(fetchAddr), .linkValue(linkValue)
  );

  // R8: every capture is followed by a redirect in the next cycle
  p_capture_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |=> strobes.redirect);
  // R7: a register jump outside a slot is fetched two cycles later
  p_reg_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (isJr && strobes.capture) |=> ##1 fetchAddr == $past(jrValue, 2));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        isBeq = 0, isBne = 0, isJump = 0, isJr = 0, isLink = 0, regsEqual = 0;
  logic [15:0] branchOffset = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] jrValue = '0;
  logic [31:0] fetchAddr, linkValue;
  logic        linkValid, slotError;

  int checks = 0;
  int failures = 0;

  logic [31:0] mPc;
  logic        mPend;
  logic [31:0] mTarget;

  always #2.5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst(rst), .isBeq(isBeq), .isBne(isBne), .isJump(isJump),
    .isJr(isJr), .isLink(isLink), .regsEqual(regsEqual),
    .branchOffset(branchOffset), .jumpField(jumpField), .jrValue(jrValue),
    .fetchAddr(fetchAddr), .linkValue(linkValue), .linkValid(linkValid),
    .slotError(slotError)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One instruction: drive decode at negedge, check combinational outputs,
  // then check the fetch address after the next rising edge.
  task automatic step(input logic b, input logic n, input logic j, input logic r,
                      input logic l, input logic eq, input logic [15:0] off,
                      input logic [25:0] fld, input logic [31:0] jrv, input string tag);
    logic        taken;
    logic [31:0] p4, tgt;
    isBeq = b; isBne = n; isJump = j; isJr = r; isLink = l; regsEqual = eq;
    branchOffset = off; jumpField = fld; jrValue = jrv;
    #1;
    p4 = mPc + 32'd4;
    check({tag, " R9 slotError"}, {31'd0, slotError}, {31'd0, mPend & (b | n | j | r)});
    check("R10 linkValid", {31'd0, linkValid}, {31'd0, l & ~mPend});
    check("R10 linkValue", linkValue, mPc + 32'd8);
    taken = ~mPend & (r | j | (b & eq) | (n & ~eq));
    if (r)      tgt = jrv;
    else if (j) tgt = {p4[31:28], fld, 2'b00};
    else        tgt = p4 + {{14{off[15]}}, off, 2'b00};
    mPc     = mPend ? mTarget : p4;
    mPend   = taken;
    mTarget = tgt;
    @(posedge clk);
    @(negedge clk);
    check(tag, fetchAddr, mPc);
  endtask

  task automatic nop(input string tag);
    step(0, 0, 0, 0, 0, 0, 16'h0, 26'h0, 32'h0, tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    isBeq = 0; isBne = 0; isJump = 0; isJr = 0; isLink = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset addr", fetchAddr, 32'h0);
    rst = 1'b0;
    mPc = 32'h0; mPend = 1'b0; mTarget = 32'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    for (int i = 0; i < 4; i++) nop("R2");

    // R3 / R4: compare outcome sweep, offsets near zero both directions
    for (int k = -20; k <= 20; k++) begin
      for (int e = 0; e < 2; e++) begin
        step(1, 0, 0, 0, 0, e[0], 16'(k), 26'h0, 32'h0, "R3 beq");
        nop("R8 slot");
        nop("R5 after");
        step(0, 1, 0, 0, 0, e[0], 16'(k + 3), 26'h0, 32'h0, "R4 bne");
        nop("R8 slot");
        nop("R5 after");
      end
    end
    // R5: extreme offsets
    step(0, 0, 0, 1, 0, 0, 16'h0, 26'h0, 32'h4000_0000, "R7 jr");
    nop("R8 slot");
    step(1, 0, 0, 0, 0, 1, 16'h7FFF, 26'h0, 32'h0, "R5 max");
    nop("R8 slot");
    step(1, 0, 0, 0, 0, 1, 16'h8000, 26'h0, 32'h0, "R5 min");
    nop("R8 slot");
    nop("R5 after min");

    // R6: jump sweep, including last word of a region
    for (int f = 0; f < 16; f++) begin
      step(0, 0, 0, 1, 0, 0, 16'h0, 26'h0, 32'h0FFF_FFF8, "R7 jr");
      nop("R8 slot");
      nop("R2 seq");
      step(0, 0, 1, 0, 1, 0, 16'h0, 26'(f * 26'h0123457), 32'h0, "R6 edge jump");
      nop("R8 slot");
      step(0, 0, 0, 1, 1, 0, 16'h0, 26'h0, {f[3:0], 28'h000_0100}, "R7 jr region");
      nop("R8 slot");
      step(0, 0, 1, 0, 0, 0, 16'h0, 26'(f * 26'h00F0F1 + 3), 32'h0, "R6 jump");
      nop("R8 slot");
    end

    // R9: transfers in delay slots are ignored
    for (int m = 0; m < 4; m++) begin
      step(1, 0, 0, 0, 0, 1, 16'h0010, 26'h0, 32'h0, "R3 beq");
      step(m == 0, m == 1, m == 2, m == 3, 1, 0, 16'h0700, 26'h155, 32'h8000_0000, "R9 in slot");
      nop("R9 after slot");
      nop("R2 seq");
    end

    // R11: priority among simultaneous flags
    step(1, 1, 1, 1, 0, 1, 16'h0040, 26'h3000, 32'h0000_2000, "R11 jr wins");
    nop("R8 slot");
    step(1, 0, 1, 0, 0, 1, 16'h0040, 26'h3000, 32'h0, "R11 jump wins");
    nop("R8 slot");
    nop("R2 seq");

    // R1: reset with a pending redirect clears it
    step(1, 0, 0, 0, 0, 1, 16'h0100, 26'h0, 32'h0, "R3 beq");
    doReset();
    nop("R1 no pending");
    nop("R2 seq");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule